// File: doc/BRIEF.md
# Serial Decimal Adder/Subtractor

This block adds or subtracts two decimal numbers that arrive one bit per clock. Each digit is a 4-bit BCD code, least significant bit first, and the least significant digit comes first. A one-hot bit strobe marks which weight (1, 2, 4, 8) is on the operand lines. A start pulse marks the first bit of the first digit of each number cycle.

A binary serial adder forms the raw digit and gathers it into a digit buffer. At the last bit of the digit, a tens detector decides whether a decimal correction is needed. During the next digit time, a second serial adder applies the correction pattern six (added or subtracted) while the digit leaves the block. Each result bit therefore trails its operand bits by four bit times. The decimal carry or borrow out of the last digit is reported to the sequencing logic, for instance to stop repeated subtraction once the result goes below zero.

Top module: `bcd_serial_addsub`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sum_bit` and `carry_flag` are 0.
- R2: `bit_stb` is one-hot and steps through bit 0, 1, 2, 3, which carry weights 1, 2, 4, 8. A result bit of weight w for digit d is registered at the clock edge four bit times after the edge that sampled the operand bits of weight w for digit d.
- R3: With `sub` = 0, each result digit is (A + B + carry-in) mod 10. A decimal carry of 1 passes to the next digit whenever that sum exceeds 9.
- R4: With `sub` = 1, each result digit is (A − B − borrow-in) mod 10. A borrow of 1 passes to the next digit whenever that difference is negative.
- R5: A `cycle_start` pulse, given together with `bit_stb[0]`, forces the carry/borrow into the first bit of digit 1 to 0. This holds even when the previous number cycle ended with a carry.
- R6: `carry_flag` takes the decimal carry (add) or borrow (subtract) out of digit DIGITS. It is loaded at the edge after the weight-8 bit of that digit and holds its value until the next such load.
- R7: With `en` = 0 for a whole number cycle, B is ignored and no correction or carry occurs. The result bits equal the A bits, including non-decimal codes, four bit times later, and `carry_flag` is loaded with 0.
- R8: A carry or borrow ripples through every digit. 999999999999 + 1 gives 0 with `carry_flag` 1, and 0 − 1 gives 999999999999 with `carry_flag` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Arithmetic enable; when low, A passes through unchanged |
| sub | input | 1 | 1 = subtract B from A, 0 = add |
| a_bit | input | 1 | Serial operand A bit |
| b_bit | input | 1 | Serial operand B bit |
| bit_stb | input | 4 | One-hot bit-weight strobe (1, 2, 4, 8) |
| cycle_start | input | 1 | First bit of digit 1 of a number cycle |
| sum_bit | output | 1 | Serial corrected result bit |
| carry_flag | output | 1 | Decimal carry/borrow out of the last digit |

## Verification
The checker assumes the following about the inputs:
- `bit_stb` is one-hot and rotates without a gap.
- `cycle_start` only coincides with the weight-1 strobe.
- `en` and `sub` stay constant across a number cycle.

The pass-through and flag properties are armed only after enough consecutive disabled cycles to flush the correction pipeline. The stimulus drives the strobe from a free-running phase counter, including during reset. It starts every operation on a digit boundary and changes the mode only between number cycles. Idle digits between operations hold `en` low with zero operands.

// File: rtl/bcd_ser_pkg.sv
`timescale 1ns/1ps
package bcd_ser_pkg;
  localparam int BITS_PER_DIGIT = 4;
  typedef logic [BITS_PER_DIGIT-1:0] digit_t;

  // Correction pattern applied when a digit leaves the decimal range
  localparam digit_t SIX = digit_t'(6);

  function automatic logic add_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

  function automatic logic sub_borrow(input logic x, input logic y, input logic b);
    return (~x & y) | (~(x ^ y) & b);
  endfunction

  // Raw 4-bit code greater than nine (10..15)
  function automatic logic above_nine(input digit_t d);
    return d[3] & (d[2] | d[1]);
  endfunction
endpackage

// File: rtl/bcd_operand_stage.sv
`timescale 1ns/1ps
// Binary serial operand adder, digit buffer, tens detector and decimal carry latch.
module bcd_operand_stage import bcd_ser_pkg::*; (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      sub,
  input  logic                      a_bit,
  input  logic                      b_bit,
  input  logic [BITS_PER_DIGIT-1:0] bit_stb,
  input  logic                      cycle_start,
  output digit_t                    raw_digit,
  output logic                      needs_fix,
  output logic                      digit_sub
);
  localparam int MSB = BITS_PER_DIGIT - 1;

  logic           carry_q;
  logic [MSB-1:0] part_q;
  logic           b_eff, cin, sum_b, cout, dec;
  digit_t         full;

  always_comb begin
    b_eff = en & b_bit;
    cin   = (cycle_start | ~en) ? 1'b0 : carry_q;
    sum_b = a_bit ^ b_eff ^ cin;
    cout  = sub ? sub_borrow(a_bit, b_eff, cin) : add_carry(a_bit, b_eff, cin);
    full  = {sum_b, part_q};
    if (!en)      dec = 1'b0;
    else if (sub) dec = cout;
    else          dec = cout | above_nine(full);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q   <= 1'b0;
      part_q    <= '0;
      raw_digit <= '0;
      needs_fix <= 1'b0;
      digit_sub <= 1'b0;
    end else begin
      for (int k = 0; k < MSB; k++) begin
        if (bit_stb[k]) part_q[k] <= sum_b;
      end
      if (bit_stb[MSB]) begin
        raw_digit <= full;
        needs_fix <= dec;
        digit_sub <= sub;
        carry_q   <= dec;
      end else begin
        carry_q <= en & cout;
      end
    end
  end
endmodule

// File: rtl/bcd_norm_stage.sv
`timescale 1ns/1ps
// Six generator and serial normalisation adder with its own in-digit carry.
module bcd_norm_stage import bcd_ser_pkg::*; (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BITS_PER_DIGIT-1:0] bit_stb,
  input  digit_t                    raw_digit,
  input  logic                      needs_fix,
  input  logic                      digit_sub,
  output logic                      sum_bit
);
  digit_t corr;
  logic   nc_q, h, c, nc_in, r, nc_out;

  always_comb begin
    corr = needs_fix ? SIX : '0;
    h = 1'b0;
    c = 1'b0;
    for (int k = 0; k < BITS_PER_DIGIT; k++) begin
      if (bit_stb[k]) begin
        h = raw_digit[k];
        c = corr[k];
      end
    end
    nc_in  = bit_stb[0] ? 1'b0 : nc_q;
    r      = h ^ c ^ nc_in;
    nc_out = digit_sub ? sub_borrow(h, c, nc_in) : add_carry(h, c, nc_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_bit <= 1'b0;
      nc_q    <= 1'b0;
    end else if (|bit_stb) begin
      sum_bit <= r;
      nc_q    <= nc_out;
    end
  end
endmodule

// File: rtl/bcd_digit_tracker.sv
`timescale 1ns/1ps
// Counts digits within a number cycle and flags the last digit's final bit.
module bcd_digit_tracker #(
  parameter int DIGITS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic digit_end,
  input  logic cycle_start,
  output logic last_digit
);
  localparam int CW = $clog2(DIGITS + 1);
  logic [CW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst)                                  idx_q <= CW'(DIGITS);
    else if (cycle_start)                     idx_q <= '0;
    else if (digit_end && idx_q != CW'(DIGITS)) idx_q <= idx_q + 1'b1;
  end

  assign last_digit = digit_end && (idx_q == CW'(DIGITS - 1));
endmodule

// File: rtl/bcd_serial_addsub.sv
`timescale 1ns/1ps
module bcd_serial_addsub import bcd_ser_pkg::*; #(
  parameter int DIGITS = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      sub,
  input  logic                      a_bit,
  input  logic                      b_bit,
  input  logic [BITS_PER_DIGIT-1:0] bit_stb,
  input  logic                      cycle_start,
  output logic                      sum_bit,
  output logic                      carry_flag
);
  digit_t raw_digit;
  logic   needs_fix, digit_sub, last_digit, last_q;

  bcd_operand_stage u_oper (
    .clk(clk), .rst(rst), .en(en), .sub(sub), .a_bit(a_bit), .b_bit(b_bit),
    .bit_stb(bit_stb), .cycle_start(cycle_start),
    .raw_digit(raw_digit), .needs_fix(needs_fix), .digit_sub(digit_sub)
  );

  bcd_norm_stage u_norm (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .raw_digit(raw_digit),
    .needs_fix(needs_fix), .digit_sub(digit_sub), .sum_bit(sum_bit)
  );

  bcd_digit_tracker #(.DIGITS(DIGITS)) u_track (
    .clk(clk), .rst(rst), .digit_end(bit_stb[BITS_PER_DIGIT-1]),
    .cycle_start(cycle_start), .last_digit(last_digit)
  );

  // Flag loads from the decimal carry latched at the end of the last digit
  always_ff @(posedge clk) begin
    if (rst) begin
      last_q     <= 1'b0;
      carry_flag <= 1'b0;
    end else begin
      last_q <= last_digit;
      if (last_q) carry_flag <= needs_fix;
    end
  end
endmodule

// File: rtl/bcd_serial_addsub_chk.sv
`timescale 1ns/1ps
module bcd_serial_addsub_chk import bcd_ser_pkg::*; (
  input logic                      clk,
  input logic                      rst,
  input logic                      en,
  input logic                      a_bit,
  input logic [BITS_PER_DIGIT-1:0] bit_stb,
  input logic                      cycle_start,
  input logic                      sum_bit,
  input logic                      carry_flag,
  input logic                      flag_load
);
  logic [3:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || en)             low_run <= '0;
    else if (low_run != 4'hF)  low_run <= low_run + 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sum_bit && !carry_flag));

  assert_stb_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(bit_stb));

  assert_start_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> bit_stb[0]);

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(flag_load) |-> $stable(carry_flag));

  assert_pass_through_R7: assert property (@(posedge clk) disable iff (rst)
    (low_run >= 4'd9) |-> (sum_bit == $past(a_bit, 5)));

  assert_idle_flag_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_load) && low_run >= 4'd2) |-> !carry_flag);
endmodule

bind bcd_serial_addsub bcd_serial_addsub_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .a_bit(a_bit), .bit_stb(bit_stb),
  .cycle_start(cycle_start), .sum_bit(sum_bit), .carry_flag(carry_flag),
  .flag_load(last_q)
);

// File: tb/bcd_serial_addsub_test.sv
`timescale 1ns/1ps
module bcd_serial_addsub_test;
  localparam int ND = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, en = 1'b0, sub = 1'b0, a_bit = 1'b0, b_bit = 1'b0, cycle_start = 1'b0;
  logic [3:0] bit_stb = 4'b0001;
  logic       sum_bit, carry_flag;

  int checks = 0, errors = 0;
  int eq[$];  string tq[$];
  int cq[$];  string ctq[$];
  int cur_carry = 0;
  int bitk = 0;
  int opa[ND], opb[ND];
  int unsigned seed = 32'h1234_5678;

  bcd_serial_addsub #(.DIGITS(ND)) uut (
    .clk(clk), .rst(rst), .en(en), .sub(sub), .a_bit(a_bit), .b_bit(b_bit),
    .bit_stb(bit_stb), .cycle_start(cycle_start), .sum_bit(sum_bit), .carry_flag(carry_flag)
  );

  task automatic check(input logic act, input int exp, input string tag);
    checks++;
    if (act !== exp[0]) begin
      errors++;
      $display("FAIL %s: got %0b expected %0d", tag, act, exp);
    end
  endtask

  // One bit time: compare outputs of the previous edge, then drive the next inputs
  task automatic tick(input logic av, input logic bv, input logic ev, input logic sv,
                      input logic cs, input int ex, input string tag, input string ctag,
                      input int new_c);
    @(negedge clk);
    if (eq.size() == 5) begin
      int e; string t;
      e = eq.pop_front(); t = tq.pop_front();
      check(sum_bit, e, t);
    end
    if (cq.size() == 2) begin
      int c; string t;
      c = cq.pop_front(); t = ctq.pop_front();
      check(carry_flag, c, t);
    end
    a_bit = av; b_bit = bv; en = ev; sub = sv; cycle_start = cs;
    bit_stb = 4'(1 << bitk);
    bitk = (bitk + 1) % 4;
    eq.push_back(ex); tq.push_back(tag);
    if (new_c >= 0) cur_carry = new_c;
    cq.push_back(cur_carry); ctq.push_back(ctag);
  endtask

  task automatic idle_to_boundary();
    while (bitk != 0) tick(0, 0, 0, 0, 0, 0, "idle", "R6", -1);
  endtask

  // Drive one number cycle from opa/opb with the reference result
  task automatic run_op(input logic ev, input logic sv, input string tag, input string ctag);
    int res[ND];
    int c = 0;
    for (int d = 0; d < ND; d++) begin
      int s;
      if (!ev) res[d] = opa[d];
      else if (!sv) begin
        s = opa[d] + opb[d] + c; c = (s > 9) ? 1 : 0; res[d] = c ? s - 10 : s;
      end else begin
        s = opa[d] - opb[d] - c; c = (s < 0) ? 1 : 0; res[d] = c ? s + 10 : s;
      end
    end
    if (!ev) c = 0;
    for (int d = 0; d < ND; d++) begin
      for (int k = 0; k < 4; k++) begin
        tick(logic'((opa[d] >> k) & 1), logic'((opb[d] >> k) & 1), ev, sv,
             (d == 0 && k == 0), (res[d] >> k) & 1, tag, ctag,
             (d == ND-1 && k == 3) ? c : -1);
      end
    end
  endtask

  function automatic int rnd_digit();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 10);
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    // R1: reset state
    repeat (6) tick(0, 0, 0, 0, 0, 0, "R1", "R1", -1);
    rst = 1'b0;
    repeat (3) tick(0, 0, 0, 0, 0, 0, "R1", "R1", -1);
    idle_to_boundary();

    // R2: weights 1,2,4,8 in order, distinct per digit
    for (int d = 0; d < ND; d++) begin opa[d] = (d % 4 == 0) ? 1 : (d % 4 == 1) ? 2 : (d % 4 == 2) ? 4 : 8; opb[d] = 0; end
    run_op(1, 0, "R2", "R6");

    // R3: addition with correction
    for (int d = 0; d < ND; d++) begin opa[d] = (d * 7 + 3) % 10; opb[d] = (d * 3 + 5) % 10; end
    run_op(1, 0, "R3", "R6");

    // R8: 999..9 + 1 ripple, flag 1; then R5 back-to-back 0 + 0 with no idle digit
    for (int d = 0; d < ND; d++) begin opa[d] = 9; opb[d] = (d == 0) ? 1 : 0; end
    run_op(1, 0, "R8", "R8");
    for (int d = 0; d < ND; d++) begin opa[d] = 0; opb[d] = 0; end
    run_op(1, 0, "R5", "R5");

    // R4: subtraction, A < B so final borrow set
    for (int d = 0; d < ND; d++) begin opa[d] = (d * 5 + 1) % 10; opb[d] = (d * 7 + 4) % 10; end
    opb[ND-1] = 9; opa[ND-1] = 2;
    run_op(1, 1, "R4", "R6");
    // R4: A > B, no final borrow
    opa[ND-1] = 9; opb[ND-1] = 1;
    run_op(1, 1, "R4", "R6");

    // R8: 0 - 1 -> all nines with borrow; then R5 back-to-back 5 - 5 = 0
    for (int d = 0; d < ND; d++) begin opa[d] = 0; opb[d] = (d == 0) ? 1 : 0; end
    run_op(1, 1, "R8", "R8");
    for (int d = 0; d < ND; d++) begin opa[d] = 5; opb[d] = 5; end
    run_op(1, 1, "R5", "R5");

    // R7: flag set by an add, then disabled cycle with non-decimal A and busy B
    for (int d = 0; d < ND; d++) begin opa[d] = 9; opb[d] = 9; end
    run_op(1, 0, "R3", "R6");
    for (int d = 0; d < ND; d++) begin opa[d] = (d + 10) % 16; opb[d] = 15 - d; end
    run_op(0, 0, "R7", "R7");
    for (int d = 0; d < ND; d++) begin opa[d] = 15 - d; opb[d] = 9; end
    run_op(0, 1, "R7", "R7");
    repeat (4) tick(0, 0, 0, 0, 0, 0, "R7", "R7", -1);

    // Mixed operands, alternating add and subtract, with idle gaps
    for (int n = 0; n < 24; n++) begin
      for (int d = 0; d < ND; d++) begin opa[d] = rnd_digit(); opb[d] = rnd_digit(); end
      run_op(1, logic'(n % 2), (n % 2) ? "R4" : "R3", "R6");
      if (n % 3 == 0) repeat (4) tick(0, 0, 0, 0, 0, 0, "R7", "R6", -1);
    end

    repeat (12) tick(0, 0, 0, 0, 0, 0, "R7", "R6", -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule